// File: doc/BRIEF.md
# Two-Level Lookahead Adder

This block adds two 32-bit operands and a carry-in in a single combinational pass. The operands are cut into eight 4-bit slices. Each slice forms a per-bit carry-creation term (both bits set) and a per-bit pass-through term (bits differ). From these it forms its internal carries as flat sums of products of its own carry-in. It also forms a slice-level create term and a slice-level pass term.

A second lookahead level produces every slice carry-in from the slice terms instead of passing carries from one slice to the next. That level is made of two tiers of four slices each. Each tier reduces its four slices to one tier create term and one tier pass term. A final stage uses those tier terms to form the carry into the upper tier, the adder carry-out, and the adder-wide create and pass outputs.

Those adder-wide terms let a wider adder built from several copies of this block run a third lookahead level over them. A stand-alone user only needs the sum and the carry-out.

Top module: `lookahead_adder32`

## Requirements
- R1: `sum` equals the low 32 bits of `opA + opB + carryIn`, treating both operands as unsigned.
- R2: `carryOut` equals bit 32 of the unsigned 33-bit result of `opA + opB + carryIn`.
- R3: `groupProp` is 1 exactly when every bit of `opA ^ opB` is 1, and 0 otherwise.
- R4: `groupGen` is 1 exactly when `opA + opB` produces a carry out of bit 31 with a carry-in of 0.
- R5: `carryOut` always equals `groupGen | (groupProp & carryIn)`.
- R6: When `opA ^ opB` is all ones, a carry-in of 1 gives `sum` = 0 and `carryOut` = 1, and a carry-in of 0 gives `sum` = all ones and `carryOut` = 0.
- R7: `groupGen` and `groupProp` are never 1 at the same time.
- R8: A carry created in any single 4-bit slice reaches every higher bit whose operand bits differ. For example, bit 31 of `sum` is correct when bit 4k+3 of both operands is 1, every higher bit has differing operand bits, and all lower bits are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opA | input | 32 | First addend |
| opB | input | 32 | Second addend |
| carryIn | input | 1 | Carry into bit 0 |
| sum | output | 32 | Low 32 bits of the result |
| carryOut | output | 1 | Carry out of bit 31 |
| groupGen | output | 1 | Adder-wide carry-create term (independent of carryIn) |
| groupProp | output | 1 | Adder-wide carry-pass term (all bits pass) |

## Verification
The checks in the bound checker are evaluated after the combinational network has settled, so they take for granted that all three inputs hold known two-state values and change together within one time step. The bench only ever drives fully defined values. It changes the operands and the carry-in at a clock edge and reads the outputs half a period later, so no check sees a half-updated input set. The stimulus covers fixed corner patterns, long pass-through chains seeded at each slice boundary, and pseudo-random operands with both carry-in values.

// File: rtl/lookahead_pkg.sv
package lookahead_pkg;

  localparam int LANE_W = 4;  // bits (or sub-terms) combined by one lookahead unit

  typedef struct packed {
    logic gen;
    logic prop;
  } gpTerm_t;

  // Carries 1..LANE_W of a lookahead unit, each a flat sum of products of
  // the create terms, the pass terms and the unit carry-in (index 0).
  function automatic logic [LANE_W:0] lookAhead(input logic [LANE_W-1:0] gen,
                                                input logic [LANE_W-1:0] prop,
                                                input logic cIn);
    logic [LANE_W:0] carry;
    logic acc;
    logic chain;
    carry[0] = cIn;
    for (int i = 0; i < LANE_W; i++) begin
      acc = 1'b0;
      for (int j = 0; j <= i; j++) begin
        chain = gen[j];
        for (int k = j + 1; k <= i; k++) chain = chain & prop[k];
        acc = acc | chain;
      end
      chain = cIn;
      for (int k = 0; k <= i; k++) chain = chain & prop[k];
      carry[i+1] = acc | chain;
    end
    return carry;
  endfunction

  // Collapse a lane of terms into one create/pass pair.
  function automatic gpTerm_t reduceLane(input logic [LANE_W-1:0] gen,
                                         input logic [LANE_W-1:0] prop);
    logic [LANE_W:0] carry;
    gpTerm_t res;
    carry    = lookAhead(gen, prop, 1'b0);
    res.gen  = carry[LANE_W];
    res.prop = &prop;
    return res;
  endfunction

endpackage

// File: rtl/lookahead_slice.sv
module lookahead_slice
  import lookahead_pkg::*;
(
  input  logic [LANE_W-1:0] sliceA,
  input  logic [LANE_W-1:0] sliceB,
  input  logic              sliceCin,
  output logic [LANE_W-1:0] sliceSum,
  output gpTerm_t           sliceTerm
);

  logic [LANE_W-1:0] bitGen;
  logic [LANE_W-1:0] bitProp;
  logic [LANE_W:0]   bitCarry;

  always_comb begin
    bitGen    = sliceA & sliceB;
    bitProp   = sliceA ^ sliceB;
    bitCarry  = lookAhead(bitGen, bitProp, sliceCin);
    sliceSum  = bitProp ^ bitCarry[LANE_W-1:0];
    sliceTerm = reduceLane(bitGen, bitProp);
  end

endmodule

// File: rtl/lookahead_tier.sv
module lookahead_tier
  import lookahead_pkg::*;
(
  input  gpTerm_t [LANE_W-1:0] laneTerms,
  input  logic                 tierCin,
  output logic [LANE_W-1:0]    laneCin,
  output gpTerm_t              tierTerm
);

  logic [LANE_W-1:0] laneGen;
  logic [LANE_W-1:0] laneProp;
  logic [LANE_W:0]   laneCarry;

  always_comb begin
    for (int i = 0; i < LANE_W; i++) begin
      laneGen[i]  = laneTerms[i].gen;
      laneProp[i] = laneTerms[i].prop;
    end
    laneCarry = lookAhead(laneGen, laneProp, tierCin);
    laneCin   = laneCarry[LANE_W-1:0];
    tierTerm  = reduceLane(laneGen, laneProp);
  end

endmodule

// File: rtl/lookahead_adder32.sv
module lookahead_adder32
  import lookahead_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic              carryIn,
  output logic [DATA_W-1:0] sum,
  output logic              carryOut,
  output logic              groupGen,
  output logic              groupProp
);

  localparam int NUM_SLICES = DATA_W / LANE_W;
  localparam int NUM_TIERS  = NUM_SLICES / LANE_W;

  gpTerm_t [NUM_SLICES-1:0] sliceTerms;
  logic    [NUM_SLICES-1:0] sliceCin;
  gpTerm_t [NUM_TIERS-1:0]  tierTerms;
  logic    [NUM_TIERS-1:0]  tierCin;
  logic    [LANE_W-1:0]     topGen;
  logic    [LANE_W-1:0]     topProp;
  logic    [LANE_W:0]       topCarry;
  logic    [LANE_W:0]       topCreate;

  for (genvar s = 0; s < NUM_SLICES; s++) begin : g_slice
    lookahead_slice u_slice (
      .sliceA   (opA[s*LANE_W +: LANE_W]),
      .sliceB   (opB[s*LANE_W +: LANE_W]),
      .sliceCin (sliceCin[s]),
      .sliceSum (sum[s*LANE_W +: LANE_W]),
      .sliceTerm(sliceTerms[s])
    );
  end

  for (genvar t = 0; t < NUM_TIERS; t++) begin : g_tier
    lookahead_tier u_tier (
      .laneTerms(sliceTerms[t*LANE_W +: LANE_W]),
      .tierCin  (tierCin[t]),
      .laneCin  (sliceCin[t*LANE_W +: LANE_W]),
      .tierTerm (tierTerms[t])
    );
  end

  // Final stage: lookahead over the tier terms; unused lanes pass nothing.
  always_comb begin
    topGen  = '0;
    topProp = '0;
    for (int t = 0; t < NUM_TIERS; t++) begin
      topGen[t]  = tierTerms[t].gen;
      topProp[t] = tierTerms[t].prop;
    end
    topCarry  = lookAhead(topGen, topProp, carryIn);
    topCreate = lookAhead(topGen, topProp, 1'b0);
    tierCin   = topCarry[NUM_TIERS-1:0];
    carryOut  = topCarry[NUM_TIERS];
    groupGen  = topCreate[NUM_TIERS];
    groupProp = &topProp[NUM_TIERS-1:0];
  end

endmodule

// File: rtl/lookahead_adder32_checker.sv
module lookahead_adder32_checker #(
  parameter int DATA_W = 32
) (
  input logic [DATA_W-1:0] opA,
  input logic [DATA_W-1:0] opB,
  input logic              carryIn,
  input logic [DATA_W-1:0] sum,
  input logic              carryOut,
  input logic              groupGen,
  input logic              groupProp
);

  logic [DATA_W:0] refFull;
  logic [DATA_W:0] refNoCin;

  always_comb begin
    refFull  = {1'b0, opA} + {1'b0, opB} + {{DATA_W{1'b0}}, carryIn};
    refNoCin = {1'b0, opA} + {1'b0, opB};
    AST_SUM_VALUE: assert final (sum == refFull[DATA_W-1:0]);                      // R1
    AST_CARRY_OUT: assert final (carryOut == refFull[DATA_W]);                      // R2
    AST_ALL_PASS: assert final (groupProp == (&(opA ^ opB)));                       // R3
    AST_CREATE_TERM: assert final (groupGen == refNoCin[DATA_W]);                   // R4
    AST_CARRY_FACTOR: assert final (carryOut == (groupGen | (groupProp & carryIn))); // R5
    AST_TERMS_EXCLUSIVE: assert final (!(groupGen && groupProp));                   // R7
  end

endmodule

bind lookahead_adder32 lookahead_adder32_checker #(.DATA_W(DATA_W)) i_checker (
  .opA      (opA),
  .opB      (opB),
  .carryIn  (carryIn),
  .sum      (sum),
  .carryOut (carryOut),
  .groupGen (groupGen),
  .groupProp(groupProp)
);

// File: tb/test_lookahead_adder32.sv
module test_lookahead_adder32;

  localparam int W = 32;
  localparam int NUM_VEC = 10;
  localparam int NUM_RAND = 4000;

  typedef struct packed {
    logic [W-1:0] a;
    logic [W-1:0] b;
    logic         c;
  } vec_t;

  localparam vec_t VECS [NUM_VEC] = '{
    '{32'h0000_0000, 32'h0000_0000, 1'b0},
    '{32'hFFFF_FFFF, 32'h0000_0001, 1'b0},
    '{32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1},
    '{32'h8000_0000, 32'h8000_0000, 1'b0},
    '{32'h1234_5678, 32'h8765_4321, 1'b1},
    '{32'h0F0F_0F0F, 32'h0F0F_0F0F, 1'b0},
    '{32'h7FFF_FFFF, 32'h0000_0000, 1'b1},
    '{32'hAAAA_AAAA, 32'h5555_5555, 1'b0},
    '{32'hDEAD_BEEF, 32'hCAFE_F00D, 1'b1},
    '{32'h0000_FFFF, 32'h0000_0001, 1'b0}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [W-1:0] opA = '0;
  logic [W-1:0] opB = '0;
  logic carryIn = 1'b0;
  logic [W-1:0] sum;
  logic carryOut, groupGen, groupProp;

  int nChecks = 0;
  int nFails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  lookahead_adder32 i_lookahead_adder32 (
    .opA(opA), .opB(opB), .carryIn(carryIn),
    .sum(sum), .carryOut(carryOut), .groupGen(groupGen), .groupProp(groupProp)
  );

  task automatic checkVal(input string req, input string what,
                          input logic [W-1:0] act, input logic [W-1:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Drive at a rising edge, read half a period later.
  task automatic applyAndCheck(input logic [W-1:0] a, input logic [W-1:0] b, input logic c);
    logic [W:0] full;
    logic [W:0] noCin;
    @(posedge clk);
    opA = a; opB = b; carryIn = c;
    @(negedge clk);
    full  = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, c};
    noCin = {1'b0, a} + {1'b0, b};
    checkVal("R1", "sum", sum, full[W-1:0]);
    checkVal("R2", "carryOut", {31'b0, carryOut}, {31'b0, full[W]});
    checkVal("R3", "groupProp", {31'b0, groupProp}, {31'b0, &(a ^ b)});
    checkVal("R4", "groupGen", {31'b0, groupGen}, {31'b0, noCin[W]});
    checkVal("R5", "carryOut factor", {31'b0, carryOut},
             {31'b0, noCin[W] | ((&(a ^ b)) & c)});
    checkVal("R7", "terms exclusive", {31'b0, groupGen & groupProp}, 32'b0);
  endtask

  initial begin
    #2000000;
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    rstN = 1'b1;
    // reset state: all-zero inputs give all-zero outputs (R1, R2)
    @(negedge clk);
    checkVal("R1", "reset sum", sum, '0);
    checkVal("R2", "reset carryOut", {31'b0, carryOut}, 32'b0);

    for (int i = 0; i < NUM_VEC; i++)
      applyAndCheck(VECS[i].a, VECS[i].b, VECS[i].c);

    // R6: full-length pass-through chain, both carry-in values
    applyAndCheck(32'hFFFF_FFFF, 32'h0000_0000, 1'b1);
    checkVal("R6", "chain sum cin1", sum, 32'h0000_0000);
    checkVal("R6", "chain cout cin1", {31'b0, carryOut}, 32'd1);
    applyAndCheck(32'h5A5A_A5A5, 32'hA5A5_5A5A, 1'b0);
    checkVal("R6", "chain sum cin0", sum, 32'hFFFF_FFFF);
    checkVal("R6", "chain cout cin0", {31'b0, carryOut}, 32'd0);

    // R8: carry created at the top bit of each slice runs to bit 31
    for (int k = 0; k < 8; k++) begin
      logic [W-1:0] hiMask;
      logic [W-1:0] seed;
      seed   = 32'h1 << (4 * k + 3);
      hiMask = ~((seed << 1) - 1);
      applyAndCheck(seed | hiMask, seed, 1'b0);
      checkVal("R8", "slice carry reaches top", sum, 32'h0);
      checkVal("R8", "slice carry out", {31'b0, carryOut}, 32'd1);
    end

    for (int i = 0; i < NUM_RAND; i++)
      applyAndCheck($urandom, $urandom, 1'($urandom));

    done = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule